// File: doc/BRIEF.md
# Graphic LCD power-up sequencer

This block takes a 128x64 serial graphic LCD controller from reset to a blank screen that is switched on. Reset puts the link in a known state: select low, serial clock high, data low. One cycle after reset is released the block raises select and waits a boot interval. It then sends a basic-mode reset and clear, waits for the controller's internal clear to finish, and switches to extended graphics mode. Next it writes zeros over every row of graphics memory, covering both halves of the screen. Last, it turns the display on, drops select and raises a sticky done flag.

All traffic goes over a three-wire serial link, most significant bit first. Each logical byte is sent as three serial bytes. The first is a sync byte that marks a command or a data byte. The second carries the upper nibble in bits 7:4 and the third carries the lower nibble in bits 7:4, with bits 3:0 of both cleared to zero. The length of each clock phase can be set through parameters. The millisecond waits come from a clock-frequency parameter, so a test setup can shrink them.

Top module: `glcd_bringup`

## Requirements
- R1: While reset is asserted, lcd_cs is 0, lcd_sclk is 1, lcd_sdat is 0 and done is 0.
- R2: lcd_cs rises one cycle after reset is released. It stays 1 until the display-on byte has been fully shifted out, and it falls in the same cycle that done rises.
- R3: No serial clock falling edge occurs within BOOT_MS*CLK_HZ/1000 cycles of lcd_cs rising.
- R4: The first three logical bytes are commands 0x20, 0x08 and 0x01, in that order.
- R5: At least SETTLE_MS*CLK_HZ/1000 cycles pass between the last clock falling edge of the 0x01 command and the first falling edge of the next byte.
- R6: After the settle wait, commands 0x24 and 0x26 follow, in that order.
- R7: For each row y from 0 to ROWS-1, in turn, the block sends command 0x80|y, then command 0x80, then 2*ROW_BYTES data bytes of 0x00.
- R8: The last logical byte is command 0x0C, and done rises after it.
- R9: Each logical byte b is sent as three serial bytes. The first is 0xF8 for a command or 0xFA for data, the second is {b[7:4],4'b0} and the third is {b[3:0],4'b0}. Bits go MSB first, and the receiver takes each bit on the rising edge of lcd_sclk.
- R10: For every bit, lcd_sclk is low for exactly LEAD_CYC+SETUP_CYC+2 cycles and then high for at least HOLD_CYC+1 cycles. lcd_sdat changes only while lcd_sclk is low.
- R11: Once done is 1, it stays 1, lcd_cs stays 0, lcd_sclk stays high, and no further clock edges occur.
- R12: A reset asserted in the middle of the script returns the outputs to the R1 state. After release, the whole script runs again from its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock at CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| lcd_cs | output | 1 | Serial select to the controller, active high |
| lcd_sclk | output | 1 | Serial clock, idles high |
| lcd_sdat | output | 1 | Serial data, MSB first |
| done | output | 1 | Sticky flag set when the bring-up script is complete |

## Verification
The block's only input is reset, so the assertions take for granted one thing about it: reset is held for at least one clock edge, which leaves every register in a defined state before any property is evaluated. The internal handshakes are assumed to be driven only by the sequencer and the framer. The bench keeps within this by holding reset for a random length of at least three cycles. It also applies one mid-script reset at a random point that lies after the boot wait, then lets the script run to completion.

// File: rtl/glcd_pkg.sv
package glcd_pkg;

   // Sync bytes that open each three-byte serial frame.
   localparam logic [7:0] SYNC_CMD = 8'hF8;
   localparam logic [7:0] SYNC_DAT = 8'hFA;

   // Command bytes of the bring-up script.
   localparam logic [7:0] OP_BASIC = 8'h20;
   localparam logic [7:0] OP_BLANK = 8'h08;
   localparam logic [7:0] OP_WIPE  = 8'h01;
   localparam logic [7:0] OP_EXT   = 8'h24;
   localparam logic [7:0] OP_GFX   = 8'h26;
   localparam logic [7:0] OP_ADDR  = 8'h80;
   localparam logic [7:0] OP_SHOW  = 8'h0C;

   typedef enum logic [1:0] {
      SH_IDLE,
      SH_LEAD,
      SH_DATA,
      SH_HIGH
   } shift_st_e;

   typedef enum logic [3:0] {
      SQ_RESET,
      SQ_BOOT,
      SQ_BASIC,
      SQ_SETTLE,
      SQ_EXT,
      SQ_ROW_Y,
      SQ_ROW_X,
      SQ_ZERO,
      SQ_ON,
      SQ_DONE
   } seq_st_e;

   // Serial byte number 'part' (0..2) of the frame for logical byte b.
   function automatic logic [7:0] frame_part(input logic [7:0] b,
                                             input logic       is_dat,
                                             input logic [1:0] part);
      case (part)
         2'd0:    frame_part = is_dat ? SYNC_DAT : SYNC_CMD;
         2'd1:    frame_part = {b[7:4], 4'b0000};
         default: frame_part = {b[3:0], 4'b0000};
      endcase
   endfunction

endpackage

// File: rtl/glcd_ms_timer.sv
module glcd_ms_timer #(
   parameter int CLK_HZ = 50_000_000,
   parameter int MSW    = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [MSW-1:0] ms,
   output logic           expired
);
   localparam int CPM = CLK_HZ / 1000;
   localparam int PW  = (CPM > 1) ? $clog2(CPM) : 1;

   logic           run;
   logic           tick;
   logic [MSW-1:0] left;
   logic           exp_q;

   if (CLK_HZ < 1000) begin : g_bad_hz
      $error("glcd_ms_timer: CLK_HZ must be at least 1000");
   end

   if (CPM <= 1) begin : g_noscale
      assign tick = run;
   end else begin : g_prescale
      logic [PW-1:0] pre;
      always_ff @(posedge clk) begin
         if (!rst_n || start || !run) pre <= '0;
         else if (pre == PW'(CPM - 1)) pre <= '0;
         else pre <= pre + 1'b1;
      end
      assign tick = run && (pre == PW'(CPM - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run   <= 1'b0;
         left  <= '0;
         exp_q <= 1'b0;
      end else begin
         exp_q <= 1'b0;
         if (start) begin
            run  <= 1'b1;
            left <= ms;
         end else if (tick) begin
            if (left <= MSW'(1)) begin
               run   <= 1'b0;
               exp_q <= 1'b1;
            end else begin
               left <= left - 1'b1;
            end
         end
      end
   end

   assign expired = exp_q;

   // R3
   exp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exp_q |=> !exp_q);
   // R5
   exp_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exp_q |-> !run);

endmodule

// File: rtl/glcd_shifter.sv
module glcd_shifter
   import glcd_pkg::*;
#(
   parameter int LEAD_CYC  = 0,
   parameter int SETUP_CYC = 0,
   parameter int HOLD_CYC  = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] din,
   output logic       idle,
   output logic       fin,
   output logic       sclk,
   output logic       sdat
);
   localparam int MAXD = (LEAD_CYC > SETUP_CYC)
                         ? ((LEAD_CYC > HOLD_CYC) ? LEAD_CYC : HOLD_CYC)
                         : ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC);
   localparam int CW   = $clog2(MAXD + 2);

   shift_st_e     st;
   logic [CW-1:0] cnt;
   logic [7:0]    shreg;
   logic [2:0]    bitn;
   logic          sclk_q, sdat_q, fin_q;

   if (LEAD_CYC < 0 || SETUP_CYC < 0 || HOLD_CYC < 0) begin : g_bad_delay
      $error("glcd_shifter: phase delays must not be negative");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= SH_IDLE;
         cnt    <= '0;
         shreg  <= '0;
         bitn   <= '0;
         sclk_q <= 1'b1;
         sdat_q <= 1'b0;
         fin_q  <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         case (st)
            SH_IDLE: if (start) begin
               shreg  <= din;
               bitn   <= '0;
               cnt    <= '0;
               sclk_q <= 1'b0;
               st     <= SH_LEAD;
            end
            SH_LEAD: if (cnt == CW'(LEAD_CYC)) begin
               sdat_q <= shreg[7];
               cnt    <= '0;
               st     <= SH_DATA;
            end else cnt <= cnt + 1'b1;
            SH_DATA: if (cnt == CW'(SETUP_CYC)) begin
               sclk_q <= 1'b1;
               cnt    <= '0;
               st     <= SH_HIGH;
            end else cnt <= cnt + 1'b1;
            SH_HIGH: if (cnt == CW'(HOLD_CYC)) begin
               cnt <= '0;
               if (bitn == 3'd7) begin
                  fin_q <= 1'b1;
                  st    <= SH_IDLE;
               end else begin
                  shreg  <= {shreg[6:0], 1'b0};
                  bitn   <= bitn + 1'b1;
                  sclk_q <= 1'b0;
                  st     <= SH_LEAD;
               end
            end else cnt <= cnt + 1'b1;
            default: st <= SH_IDLE;
         endcase
      end
   end

   assign idle = (st == SH_IDLE);
   assign fin  = fin_q;
   assign sclk = sclk_q;
   assign sdat = sdat_q;

   // R10
   data_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdat_q) |-> !sclk_q);
   // R10
   idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SH_IDLE) |-> sclk_q);

endmodule

// File: rtl/glcd_framer.sv
module glcd_framer
   import glcd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] byte_in,
   input  logic       is_dat,
   output logic       busy,
   output logic       fin,
   output logic       ser_start,
   output logic [7:0] ser_byte,
   input  logic       ser_idle,
   input  logic       ser_fin
);
   logic [1:0] part;
   logic [7:0] lat_b;
   logic       lat_d;
   logic       busy_q, start_q, fin_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         part    <= '0;
         lat_b   <= '0;
         lat_d   <= 1'b0;
         busy_q  <= 1'b0;
         start_q <= 1'b0;
         fin_q   <= 1'b0;
      end else begin
         start_q <= 1'b0;
         fin_q   <= 1'b0;
         if (go && !busy_q) begin
            lat_b   <= byte_in;
            lat_d   <= is_dat;
            part    <= 2'd0;
            busy_q  <= 1'b1;
            start_q <= 1'b1;
         end else if (busy_q && ser_fin) begin
            if (part == 2'd2) begin
               busy_q <= 1'b0;
               fin_q  <= 1'b1;
            end else begin
               part    <= part + 1'b1;
               start_q <= 1'b1;
            end
         end
      end
   end

   assign busy      = busy_q;
   assign fin       = fin_q;
   assign ser_start = start_q;
   assign ser_byte  = frame_part(lat_b, lat_d, part);

   // R9
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> ser_idle);
   // R9
   go_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !busy_q);

endmodule

// File: rtl/glcd_bringup.sv
module glcd_bringup
   import glcd_pkg::*;
#(
   parameter int CLK_HZ    = 50_000_000,
   parameter int BOOT_MS   = 120,
   parameter int SETTLE_MS = 15,
   parameter int ROWS      = 32,
   parameter int ROW_BYTES = 16,
   parameter int LEAD_CYC  = 0,
   parameter int SETUP_CYC = 0,
   parameter int HOLD_CYC  = 0
) (
   input  logic clk,
   input  logic rst_n,
   output logic lcd_cs,
   output logic lcd_sclk,
   output logic lcd_sdat,
   output logic done
);
   localparam int MAXMS = (BOOT_MS > SETTLE_MS) ? BOOT_MS : SETTLE_MS;
   localparam int MSW   = $clog2(MAXMS + 1);
   localparam int ZEROS = 2 * ROW_BYTES;
   localparam int ZW    = $clog2(ZEROS + 1);
   localparam int YW    = $clog2(ROWS + 1);

   if (ROWS < 1 || ROWS > 32) begin : g_bad_rows
      $error("glcd_bringup: ROWS must be 1..32");
   end
   if (ROW_BYTES < 1) begin : g_bad_width
      $error("glcd_bringup: ROW_BYTES must be at least 1");
   end
   if (BOOT_MS < 1 || SETTLE_MS < 1) begin : g_bad_wait
      $error("glcd_bringup: waits must be at least 1 ms");
   end

   seq_st_e        st;
   logic           issued;
   logic [ZW-1:0]  cnt;
   logic [YW-1:0]  row;
   logic           go_q, dat_q;
   logic [7:0]     byte_q;
   logic           tmr_go;
   logic [MSW-1:0] tmr_ms;
   logic           tmr_exp;
   logic           cs_q, done_q;
   logic           fr_busy, fr_fin;
   logic           ser_start, ser_idle, ser_fin;
   logic [7:0]     ser_byte;
   logic           sending;
   logic [7:0]     cur_byte;
   logic           cur_dat;

   always_comb begin
      sending  = 1'b1;
      cur_dat  = 1'b0;
      cur_byte = 8'h00;
      case (st)
         SQ_BASIC: cur_byte = (cnt == ZW'(0)) ? OP_BASIC :
                              (cnt == ZW'(1)) ? OP_BLANK : OP_WIPE;
         SQ_EXT:   cur_byte = (cnt == ZW'(0)) ? OP_EXT : OP_GFX;
         SQ_ROW_Y: cur_byte = OP_ADDR | 8'(row);
         SQ_ROW_X: cur_byte = OP_ADDR;
         SQ_ZERO:  cur_dat  = 1'b1;
         SQ_ON:    cur_byte = OP_SHOW;
         default:  sending  = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= SQ_RESET;
         issued <= 1'b0;
         cnt    <= '0;
         row    <= '0;
         go_q   <= 1'b0;
         dat_q  <= 1'b0;
         byte_q <= '0;
         tmr_go <= 1'b0;
         tmr_ms <= '0;
         cs_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         go_q   <= 1'b0;
         tmr_go <= 1'b0;
         if (sending) begin
            if (!issued) begin
               go_q   <= 1'b1;
               byte_q <= cur_byte;
               dat_q  <= cur_dat;
               issued <= 1'b1;
            end else if (fr_fin) begin
               issued <= 1'b0;
               case (st)
                  SQ_BASIC: if (cnt == ZW'(2)) begin
                     tmr_go <= 1'b1;
                     tmr_ms <= MSW'(SETTLE_MS);
                     st     <= SQ_SETTLE;
                  end else cnt <= cnt + 1'b1;
                  SQ_EXT: if (cnt == ZW'(1)) begin
                     row <= '0;
                     st  <= SQ_ROW_Y;
                  end else cnt <= cnt + 1'b1;
                  SQ_ROW_Y: st <= SQ_ROW_X;
                  SQ_ROW_X: begin
                     cnt <= '0;
                     st  <= SQ_ZERO;
                  end
                  SQ_ZERO: if (cnt == ZW'(ZEROS - 1)) begin
                     if (row == YW'(ROWS - 1)) st <= SQ_ON;
                     else begin
                        row <= row + 1'b1;
                        st  <= SQ_ROW_Y;
                     end
                  end else cnt <= cnt + 1'b1;
                  default: begin
                     cs_q   <= 1'b0;
                     done_q <= 1'b1;
                     st     <= SQ_DONE;
                  end
               endcase
            end
         end else begin
            case (st)
               SQ_RESET: begin
                  cs_q   <= 1'b1;
                  tmr_go <= 1'b1;
                  tmr_ms <= MSW'(BOOT_MS);
                  st     <= SQ_BOOT;
               end
               SQ_BOOT: if (tmr_exp) begin
                  cnt <= '0;
                  st  <= SQ_BASIC;
               end
               SQ_SETTLE: if (tmr_exp) begin
                  cnt <= '0;
                  st  <= SQ_EXT;
               end
               default: st <= SQ_DONE;
            endcase
         end
      end
   end

   glcd_ms_timer #(.CLK_HZ(CLK_HZ), .MSW(MSW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (tmr_go),
      .ms      (tmr_ms),
      .expired (tmr_exp)
   );

   glcd_framer u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go_q),
      .byte_in   (byte_q),
      .is_dat    (dat_q),
      .busy      (fr_busy),
      .fin       (fr_fin),
      .ser_start (ser_start),
      .ser_byte  (ser_byte),
      .ser_idle  (ser_idle),
      .ser_fin   (ser_fin)
   );

   glcd_shifter #(
      .LEAD_CYC  (LEAD_CYC),
      .SETUP_CYC (SETUP_CYC),
      .HOLD_CYC  (HOLD_CYC)
   ) u_shifter (
      .clk   (clk),
      .rst_n (rst_n),
      .start (ser_start),
      .din   (ser_byte),
      .idle  (ser_idle),
      .fin   (ser_fin),
      .sclk  (lcd_sclk),
      .sdat  (lcd_sdat)
   );

   assign lcd_cs = cs_q;
   assign done   = done_q;

   // R2
   cs_drop_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_q) |-> done_q);
   // R11
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> done_q);
   // R11
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!cs_q && lcd_sclk && !fr_busy));
   // R3
   boot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_BOOT) |-> (lcd_sclk && !fr_busy));
   // R2
   clk_only_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_q |-> lcd_sclk);

endmodule

// File: tb/tb_glcd_bringup.sv
module tb_glcd_bringup;
   localparam int CLK_HZ = 8000;
   localparam int BOOT   = 120;
   localparam int SETTLE = 15;
   localparam int ROWS   = 4;
   localparam int RB     = 3;
   localparam int D1     = 1;
   localparam int D2     = 2;
   localparam int D3     = 0;
   localparam int CPM    = CLK_HZ / 1000;
   localparam int BLK    = 2 + 2 * RB;
   localparam int NLOG   = 5 + ROWS * BLK + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lcd_cs, lcd_sclk, lcd_sdat, done;

   always #10 clk = ~clk;

   glcd_bringup #(
      .CLK_HZ(CLK_HZ), .BOOT_MS(BOOT), .SETTLE_MS(SETTLE),
      .ROWS(ROWS), .ROW_BYTES(RB),
      .LEAD_CYC(D1), .SETUP_CYC(D2), .HOLD_CYC(D3)
   ) dut (
      .clk(clk), .rst_n(rst_n),
      .lcd_cs(lcd_cs), .lcd_sclk(lcd_sclk), .lcd_sdat(lcd_sdat), .done(done)
   );

   int pass_n = 0, tot_n = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tot_n++;
      if (ok) pass_n++;
      else $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  %0d/%0d checks passed", pass_n, tot_n);
         $finish;
      end
   endtask

   // Expected logical byte k: {is_data, byte}.
   function automatic logic [8:0] exp_log(input int k);
      int r, j;
      if (k == 0) return {1'b0, 8'h20};
      if (k == 1) return {1'b0, 8'h08};
      if (k == 2) return {1'b0, 8'h01};
      if (k == 3) return {1'b0, 8'h24};
      if (k == 4) return {1'b0, 8'h26};
      if (k < 5 + ROWS * BLK) begin
         r = (k - 5) / BLK;
         j = (k - 5) % BLK;
         if (j == 0) return {1'b0, 8'h80 | 8'(r)};
         if (j == 1) return {1'b0, 8'h80};
         return {1'b1, 8'h00};
      end
      return {1'b0, 8'h0C};
   endfunction

   function automatic string tag_of(input int k);
      if (k < 3) return "R4";
      if (k < 5) return "R6";
      if (k < 5 + ROWS * BLK) return "R7";
      return "R8";
   endfunction

   // Link monitor, sampled on the falling clock edge.
   int cyc = 0;
   int nbits, nfall, nsb, low_run, high_run;
   int low_bad, high_bad, chg_bad, cs_bad, cs_rise;
   logic [7:0] acc;
   logic [7:0] sb [0:255];
   int falls [0:1023];
   logic prev_sclk = 1'b1, prev_sdat = 1'b0, prev_cs = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         nbits = 0; nfall = 0; nsb = 0; low_run = 0; high_run = 0;
         low_bad = 0; high_bad = 0; chg_bad = 0; cs_bad = 0; cs_rise = -1;
         acc = '0;
      end else begin
         if (!prev_cs && lcd_cs) cs_rise = cyc;
         if (prev_cs && !lcd_cs && !done) cs_bad++;
         if (lcd_sclk && prev_sclk && (lcd_sdat !== prev_sdat)) chg_bad++;
         if (prev_sclk && !lcd_sclk) begin
            if (nfall > 0 && high_run < D3 + 1) high_bad++;
            if (nfall < 1024) falls[nfall] = cyc;
            nfall++;
            high_run = 0;
         end
         if (!prev_sclk && lcd_sclk) begin
            if (low_run != D1 + D2 + 2) low_bad++;
            low_run = 0;
            acc = {acc[6:0], lcd_sdat};
            nbits++;
            if (nbits % 8 == 0) begin
               if (nsb < 256) sb[nsb] = acc;
               nsb++;
            end
         end
         if (lcd_sclk) high_run++;
         else low_run++;
      end
      prev_sclk = lcd_sclk;
      prev_sdat = lcd_sdat;
      prev_cs   = lcd_cs;
   end

   initial begin
      repeat (60000) @(posedge clk);
      chk(0, "WDOG", "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      int hold, abort_at, k, lastfall, got, ok, frames_bad;
      logic [8:0] e;
      void'($urandom(32'd4242));
      hold = 3 + ($urandom % 8);
      repeat (hold) @(negedge clk);
      // R1: reset state
      chk(lcd_cs == 0 && lcd_sclk == 1 && lcd_sdat == 0 && done == 0, "R1",
          "reset outputs", {lcd_cs, lcd_sclk, lcd_sdat, done}, 4'b0100);
      @(posedge clk); rst_n = 1;
      @(negedge clk); @(negedge clk);
      chk(lcd_cs == 1, "R2", "cs one cycle after release", lcd_cs, 1);
      // random mid-script abort after the boot wait
      abort_at = BOOT * CPM + 100 + ($urandom % 1500);
      repeat (abort_at) @(negedge clk);
      chk(done == 0 && nfall > 0, "R12", "script active before abort", nfall > 0, 1);
      rst_n = 0;
      @(negedge clk); @(negedge clk);
      chk(lcd_cs == 0 && lcd_sclk == 1 && lcd_sdat == 0 && done == 0, "R12",
          "outputs after mid-script reset", {lcd_cs, lcd_sclk, lcd_sdat, done}, 4'b0100);
      @(posedge clk); rst_n = 1;
      while (!done) @(negedge clk);
      // sequence after restart
      chk(nsb == 3 * NLOG && nbits % 8 == 0, "R9", "serial byte count", nsb, 3 * NLOG);
      frames_bad = 0;
      for (int i = 0; i < NLOG; i++) begin
         e = exp_log(i);
         if (3 * i + 2 < nsb) begin
            if (sb[3 * i] != (e[8] ? 8'hFA : 8'hF8)) frames_bad++;
            got = {sb[3 * i + 1][7:4], sb[3 * i + 2][7:4]};
            ok = (sb[3 * i + 1][3:0] == 0) && (sb[3 * i + 2][3:0] == 0) && (got == e[7:0]);
            chk(ok != 0, tag_of(i), $sformatf("logical byte %0d", i), got, e[7:0]);
         end else begin
            chk(0, tag_of(i), $sformatf("logical byte %0d missing", i), 0, e[7:0]);
         end
      end
      chk(frames_bad == 0, "R9", "sync bytes wrong", frames_bad, 0);
      // R3: boot wait
      k = falls[0] - cs_rise;
      chk(cs_rise >= 0 && k >= BOOT * CPM && k <= BOOT * CPM + 12, "R3",
          "cs rise to first clock", k, BOOT * CPM);
      // R5: settle gap between bit 71 and bit 72
      k = falls[72] - falls[71];
      chk(k >= SETTLE * CPM && k <= SETTLE * CPM + 40, "R5", "settle gap", k, SETTLE * CPM);
      chk(low_bad == 0, "R10", "clock low length errors", low_bad, 0);
      chk(high_bad == 0, "R10", "clock high too short", high_bad, 0);
      chk(chg_bad == 0, "R10", "data changed while clock high", chg_bad, 0);
      chk(cs_bad == 0 && lcd_cs == 0, "R2", "cs dropped only with done", cs_bad, 0);
      // R11: quiet after done
      lastfall = nfall;
      repeat (40 + ($urandom % 40)) @(negedge clk);
      chk(done == 1, "R11", "done sticky", done, 1);
      chk(lcd_cs == 0 && lcd_sclk == 1, "R11", "link idle after done",
          {lcd_cs, lcd_sclk}, 2'b01);
      chk(nfall == lastfall, "R11", "clock edges after done", nfall, lastfall);
      summary();
   end

endmodule